// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block holds the event and status word that a DMA controller presents to host software. The transmit and receive process controllers send one-cycle event pulses. Each pulse sets a sticky bit that stays set until software writes a 1 to it. Software can service these bits from an interrupt handler or by polling the register.

The same word also shows the live 3-bit state code of each DMA process. These codes are read-only and never raise an interrupt. A separate enable register selects which events count toward the normal-interrupt summary bit. The block's single interrupt output follows that summary bit.

Access goes through a plain register port. A write is a single-cycle strobe with an address and data. Read data is a combinational function of the address. There is no handshake at the port.

Top module: `dma_irq_status`

## Requirements
- R1: After reset the status word (address 0x14) and the enable register (address 0x1C) both read 0x00000000, and `irq` is 0.
- R2: A 1 on `evt_pulse[i]` (i in 0..15) at a rising edge sets status bit i from that edge on. The bit stays set until it is cleared.
- R3: A write to address 0x14 clears each status bit in 15:0 whose data bit is 1. Data bits that are 0 leave the matching status bits unchanged.
- R4: When an event pulse and a clearing write hit the same bit at the same edge, the bit is 1 afterwards.
- R5: Status bit 16 is the summary. It is 1 exactly when at least one of the status bits 0, 2, 6 or 14 is set and the enable register bit at the same position is also set.
- R6: Status bits 1, 3–5, 7–13 and 15 never affect bit 16 or `irq`, even when they are enabled.
- R7: `irq` equals status bit 16 at all times.
- R8: Status bits 22:20 show `tx_state` and bits 19:17 show `rx_state`, each as sampled at the previous rising edge. Writes do not change them, and they never set bit 16 or `irq`.
- R9: Status bits 31:23 always read 0, and writing to them has no effect.
- R10: The enable register at 0x1C stores write data bits 15:0 and reads bits 31:16 as 0.
- R11: A write to any address other than 0x14 or 0x1C changes nothing. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wen | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| evt_pulse | input | 16 | Event pulses, one per status bit 15:0 |
| tx_state | input | 3 | Live transmit process state code |
| rx_state | input | 3 | Live receive process state code |
| irq | output | 1 | Interrupt request, equal to the summary bit |

## Verification
Two things can happen to one sticky bit in the same cycle: a new event can set it while a write-1 clears it. The bench forces this by driving `evt_pulse[2]` during the same write strobe that clears bit 2. It then checks that bit 2 reads 1 afterwards. A second collision is a state-code change during a write of all ones to the status word. The bench checks that the state fields show the new codes, the reserved bits stay 0, and no state code raises `irq`.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int ADDR_W  = 8;
  localparam int DATA_W  = 32;
  localparam int EVT_W   = 16;
  localparam int ST_W    = 3;
  localparam int SUM_BIT = 16;
  localparam int RX_LSB  = 17;
  localparam int TX_LSB  = 20;
  localparam int RSV_LSB = TX_LSB + ST_W;
  // events feeding the normal summary: bits 0, 2, 6, 14
  localparam logic [EVT_W-1:0] SUM_SEL = 16'h4045;
  localparam logic [ADDR_W-1:0] STATUS_OFS = 8'h14;
  localparam logic [ADDR_W-1:0] ENABLE_OFS = 8'h1C;
endpackage

// File: rtl/dma_irq_evt_bank.sv
module dma_irq_evt_bank #(
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] evt_i,
  input  logic [EVT_W-1:0] clr_i,
  output logic [EVT_W-1:0] sticky_o
);
  for (genvar g = 0; g < EVT_W; g++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (evt_i[g]) q <= 1'b1;
      else if (clr_i[g]) q <= 1'b0;
    end
    assign sticky_o[g] = q;

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> sticky_o[g]);
    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !evt_i[g]) |=> !sticky_o[g]);
    assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_o[g] && !clr_i[g]) |=> sticky_o[g]);
  end
endmodule

// File: rtl/dma_irq_enable_reg.sv
module dma_irq_enable_reg #(
  parameter int EVT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [EVT_W-1:0] wdata_i,
  output logic [EVT_W-1:0] en_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    en_o <= '0;
    else if (we_i) en_o <= wdata_i;
  end

  assert_en_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(en_o));
endmodule

// File: rtl/dma_irq_summary.sv
module dma_irq_summary #(
  parameter int               EVT_W = 16,
  parameter logic [EVT_W-1:0] SEL   = '1
) (
  input  logic [EVT_W-1:0] sticky_i,
  input  logic [EVT_W-1:0] en_i,
  output logic             summary_o
);
  logic [EVT_W-1:0] hit;
  for (genvar g = 0; g < EVT_W; g++) begin : g_sel
    if (SEL[g]) begin : g_on
      assign hit[g] = sticky_i[g] & en_i[g];
    end else begin : g_off
      assign hit[g] = 1'b0;
    end
  end
  assign summary_o = |hit;
endmodule

// File: rtl/dma_irq_state_cap.sv
module dma_irq_state_cap #(
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ST_W-1:0] tx_i,
  input  logic [ST_W-1:0] rx_i,
  output logic [ST_W-1:0] tx_q,
  output logic [ST_W-1:0] rx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_q <= '0;
      rx_q <= '0;
    end else begin
      tx_q <= tx_i;
      rx_q <= rx_i;
    end
  end

  assert_state_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (tx_q == $past(tx_i)) && (rx_q == $past(rx_i)));
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [EVT_W-1:0]  evt_pulse,
  input  logic [ST_W-1:0]   tx_state,
  input  logic [ST_W-1:0]   rx_state,
  output logic              irq
);
  logic              st_hit, en_hit;
  logic [EVT_W-1:0]  clr_vec, sticky, en;
  logic [ST_W-1:0]   tx_q, rx_q;
  logic              summary;
  logic [DATA_W-1:0] status_word, enable_word;

  assign st_hit  = (bus_addr == STATUS_OFS);
  assign en_hit  = (bus_addr == ENABLE_OFS);
  assign clr_vec = (bus_wen && st_hit) ? bus_wdata[EVT_W-1:0] : '0;

  dma_irq_evt_bank #(.EVT_W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_pulse), .clr_i(clr_vec), .sticky_o(sticky)
  );

  dma_irq_enable_reg #(.EVT_W(EVT_W)) u_en (
    .clk(clk), .rst_n(rst_n), .we_i(bus_wen && en_hit),
    .wdata_i(bus_wdata[EVT_W-1:0]), .en_o(en)
  );

  dma_irq_summary #(.EVT_W(EVT_W), .SEL(SUM_SEL)) u_sum (
    .sticky_i(sticky), .en_i(en), .summary_o(summary)
  );

  dma_irq_state_cap #(.ST_W(ST_W)) u_st (
    .clk(clk), .rst_n(rst_n), .tx_i(tx_state), .rx_i(rx_state), .tx_q(tx_q), .rx_q(rx_q)
  );

  always_comb begin
    status_word = '0;
    status_word[EVT_W-1:0]            = sticky;
    status_word[SUM_BIT]              = summary;
    status_word[RX_LSB +: ST_W]       = rx_q;
    status_word[TX_LSB +: ST_W]       = tx_q;
    enable_word = '0;
    enable_word[EVT_W-1:0]            = en;
  end

  always_comb begin
    if (st_hit)      bus_rdata = status_word;
    else if (en_hit) bus_rdata = enable_word;
    else             bus_rdata = '0;
  end

  assign irq = summary;

  assert_masked_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky & en & SUM_SEL) == '0) |-> !irq);
  assert_summary_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky & en & SUM_SEL) != '0) |-> irq);
  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit |-> (bus_rdata[DATA_W-1:RSV_LSB] == '0));
  assert_irq_is_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    st_hit |-> (bus_rdata[SUM_BIT] == irq));
endmodule

// File: tb/sim_dma_irq_status.sv
module sim_dma_irq_status;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_wen = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] evt_pulse = '0;
  logic [2:0]  tx_state = '0;
  logic [2:0]  rx_state = '0;
  logic        irq;
  int checks = 0;
  int fails = 0;

  localparam logic [7:0] A_ST = 8'h14;
  localparam logic [7:0] A_EN = 8'h1C;

  always #5 clk = ~clk;

  dma_irq_status u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    @(negedge clk);
    bus_addr = a;
    #1 v = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_wdata = '0;
  endtask

  task automatic pulse(input logic [15:0] p);
    @(negedge clk);
    evt_pulse = p;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(A_ST, v); check("R1 status", v, 32'h0);
    rd(A_EN, v); check("R1 enable", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_enable;
    logic [31:0] v;
    wr(A_EN, 32'hFFFF_FFFF);
    rd(A_EN, v); check("R10 enable readback", v, 32'h0000_FFFF);
    wr(A_EN, 32'h0);
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    pulse(16'h0008);
    rd(A_ST, v); check("R2 bit3 set", v, 32'h0000_0008);
    repeat (5) @(negedge clk);
    rd(A_ST, v); check("R2 bit3 held", v, 32'h0000_0008);
    wr(A_ST, 32'hFFFF_FFF7);
    rd(A_ST, v); check("R3 zero-write keeps", v, 32'h0000_0008);
    wr(A_ST, 32'h0000_0008);
    rd(A_ST, v); check("R3 w1c clears", v, 32'h0);
  endtask

  task automatic t_summary;
    logic [31:0] v;
    int pos[4] = '{0, 2, 6, 14};
    foreach (pos[k]) begin
      wr(A_EN, 32'h0);
      pulse(16'(1 << pos[k]));
      rd(A_ST, v); check("R5 masked no summary", v, 32'(1 << pos[k]));
      check("R7 irq low", {31'b0, irq}, 32'h0);
      wr(A_EN, 32'(1 << pos[k]));
      rd(A_ST, v); check("R5 enabled summary", v, 32'(1 << pos[k]) | 32'h1_0000);
      check("R7 irq high", {31'b0, irq}, 32'h1);
      wr(A_ST, 32'(1 << pos[k]));
      rd(A_ST, v); check("R5 cleared summary", v, 32'h0);
      check("R7 irq cleared", {31'b0, irq}, 32'h0);
    end
  endtask

  task automatic t_nonsum;
    logic [31:0] v;
    wr(A_EN, 32'h0000_FFFF);
    pulse(16'hBFBA);
    rd(A_ST, v); check("R6 other events ignored", v, 32'h0000_BFBA);
    check("R6 irq low", {31'b0, irq}, 32'h0);
    wr(A_ST, 32'h0000_FFFF);
    rd(A_ST, v); check("R3 clear all", v, 32'h0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    wr(A_EN, 32'h0);
    pulse(16'h0024);
    @(negedge clk);
    bus_addr = A_ST; bus_wdata = 32'h0000_0024; bus_wen = 1'b1; evt_pulse = 16'h0004;
    @(negedge clk);
    bus_wen = 1'b0; bus_wdata = '0; evt_pulse = '0;
    rd(A_ST, v); check("R4 set wins over clear", v, 32'h0000_0004);
    wr(A_ST, 32'h0000_0004);
  endtask

  task automatic t_state;
    logic [31:0] v;
    wr(A_EN, 32'h0000_FFFF);
    @(negedge clk);
    tx_state = 3'd5; rx_state = 3'd3;
    bus_addr = A_ST; bus_wdata = 32'hFFFF_FFFF; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0; bus_wdata = '0;
    rd(A_ST, v); check("R8 state fields", v, (32'd5 << 20) | (32'd3 << 17));
    check("R8 state no irq", {31'b0, irq}, 32'h0);
    check("R9 reserved zero", v & 32'hFF80_0000, 32'h0);
    @(negedge clk);
    tx_state = 3'd7; rx_state = 3'd6;
    rd(A_ST, v); check("R8 state tracks", v, (32'd7 << 20) | (32'd6 << 17));
    wr(A_EN, 32'h0);
  endtask

  task automatic t_other;
    logic [31:0] v;
    pulse(16'h0001);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(A_ST, v); check("R11 foreign write status", v & 32'h1_FFFF, 32'h0000_0001);
    rd(A_EN, v); check("R11 foreign write enable", v, 32'h0);
    rd(8'h20, v); check("R11 foreign read", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_enable();
    t_sticky();
    t_summary();
    t_nonsum();
    t_collide();
    t_state();
    t_other();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule